// File: doc/BRIEF.md
# Nibble-Bus Firmware Read Host

This block is the initiating side of a 4-bit multiplexed firmware bus and performs single-byte memory reads. A client gives it a 28-bit memory address and a 4-bit target identifier. The host then runs one complete read cycle on the bus: a one-clock frame strobe with the start code, the target identifier, seven address nibbles, a one-byte size code, a handover of the bus to the target, a wait for the target's ready code, two data nibbles and a final handback. At the end it returns the byte together with a single-clock completion pulse.

The bus pad is split into an output value, an output enable and an input value, so the tri-state buffer can sit in the pad ring. If the target never reports ready within a fixed number of clocks, the host abandons the cycle, raises a one-clock timeout flag and goes back to idle. Requests are taken only while the host is idle.

Top module: `fwh_read_host`

## Requirements
- R1: After reset, busy, done, sync_timeout and bus_oe are 0 and bus_frame_n is 1.
- R2: In the clock after a request is accepted, bus_frame_n is 0, bus_oe is 1 and bus_dout is 4'b1101. bus_frame_n is low for that one clock only and stays 1 for the rest of the cycle.
- R3: The clock after the start code drives req_id on bus_dout.
- R4: The next seven clocks drive the latched address one nibble per clock, bits 27:24 first and bits 3:0 last.
- R5: The clock after the last address nibble drives the size code 4'b0000.
- R6: The next clock drives 4'b1111 with bus_oe high. From the following clock onward, bus_oe stays 0 until the cycle ends.
- R7: From the second clock after the 4'b1111 clock, bus_din is sampled every clock. The value 4'b0000 means ready. Any other value means the target is still waiting.
- R8: The clock after ready carries data bits 3:0 and the clock after that carries bits 7:4. rd_data presents them as {high nibble, low nibble}.
- R9: After the high nibble, the host leaves the bus undriven for two clocks. In the clock after those two, done is 1 for exactly one clock, rd_data holds the byte and busy is 0.
- R10: If SYNC_TIMEOUT consecutive sampling clocks pass without 4'b0000, sync_timeout is 1 for exactly one clock in the following clock. done stays 0, busy is 0 and the bus is undriven.
- R11: A request is accepted only while busy is 0, and busy stays 1 from the start code to the end of the cycle. req_valid and the request fields have no effect while busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request strobe |
| req_addr | input | 28 | Memory address of the byte |
| req_id | input | 4 | Target identifier |
| busy | output | 1 | A bus cycle is in progress |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Byte that was read |
| sync_timeout | output | 1 | One-clock pulse when the cycle is abandoned |
| bus_frame_n | output | 1 | Active-low frame strobe |
| bus_dout | output | 4 | Value driven onto the nibble bus |
| bus_oe | output | 1 | Enable for driving the nibble bus |
| bus_din | input | 4 | Value sampled from the nibble bus |

## Verification
The assertions check the following on every clock: the frame strobe appears only with the start code and lasts a single clock, the bus is never driven while idle, output enable drops only after an all-ones nibble, done and timeout are one-clock pulses that never coincide, and an accepted request always leads to a frame strobe. The bench scenarios cover what the properties cannot see. These are the exact order of the identifier, address and size nibbles, the varying wait lengths before ready (including the last clock that still succeeds and the first clock that times out), the low-then-high rebuilding of the byte, and requests made while busy being ignored.

// File: rtl/fwh_host_pkg.sv
package fwh_host_pkg;

    localparam int NIB_W      = 4;
    localparam int ADDR_W     = 28;
    localparam int ID_W       = 4;
    localparam int BYTE_W     = 8;
    localparam int ADDR_NIBS  = ADDR_W / NIB_W;
    localparam int NIB_IDX_W  = $clog2(ADDR_NIBS);

    localparam logic [NIB_W-1:0] CODE_START  = 4'b1101;
    localparam logic [NIB_W-1:0] CODE_SIZE1  = 4'b0000;
    localparam logic [NIB_W-1:0] CODE_READY  = 4'b0000;
    localparam logic [NIB_W-1:0] CODE_ONES   = 4'b1111;

    typedef enum logic [3:0] {
        HS_IDLE,
        HS_START,
        HS_IDSEL,
        HS_ADDR,
        HS_SIZE,
        HS_TAR_DRIVE,
        HS_TAR_FLOAT,
        HS_SYNC,
        HS_DATA_LO,
        HS_DATA_HI,
        HS_RET_TAR0,
        HS_RET_TAR1
    } hstate_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ID_W-1:0]   id;
    } rd_req_t;

    typedef struct packed {
        logic             frame_n;
        logic             oe;
        logic [NIB_W-1:0] dout;
    } bus_drv_t;

    function automatic logic [NIB_W-1:0] addr_nibble(
        input logic [ADDR_W-1:0]    a,
        input logic [NIB_IDX_W-1:0] idx
    );
        return a[{idx, 2'b00} +: NIB_W];
    endfunction

endpackage

// File: rtl/fwh_host_seq.sv
module fwh_host_seq
    import fwh_host_pkg::*;
#(
    parameter int SYNC_TIMEOUT = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  rd_req_t              req_in,
    input  logic [NIB_W-1:0]     bus_din,
    output hstate_e              state,
    output rd_req_t              req_q,
    output logic [NIB_IDX_W-1:0] nib_idx,
    output logic                 done_q,
    output logic                 tmo_q
);

    localparam int WAIT_W = $clog2(SYNC_TIMEOUT + 1);
    localparam logic [WAIT_W-1:0]    WAIT_LAST = WAIT_W'(SYNC_TIMEOUT - 1);
    localparam logic [NIB_IDX_W-1:0] NIB_TOP   = NIB_IDX_W'(ADDR_NIBS - 1);

    logic [WAIT_W-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= HS_IDLE;
            req_q    <= '0;
            nib_idx  <= '0;
            wait_cnt <= '0;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            tmo_q  <= 1'b0;
            unique case (state)
                HS_IDLE: begin
                    if (req_valid) begin
                        req_q <= req_in;
                        state <= HS_START;
                    end
                end
                HS_START:  state <= HS_IDSEL;
                HS_IDSEL: begin
                    nib_idx <= NIB_TOP;
                    state   <= HS_ADDR;
                end
                HS_ADDR: begin
                    if (nib_idx == '0) state <= HS_SIZE;
                    else               nib_idx <= nib_idx - 1'b1;
                end
                HS_SIZE:      state <= HS_TAR_DRIVE;
                HS_TAR_DRIVE: state <= HS_TAR_FLOAT;
                HS_TAR_FLOAT: begin
                    wait_cnt <= '0;
                    state    <= HS_SYNC;
                end
                HS_SYNC: begin
                    if (bus_din == CODE_READY) begin
                        state <= HS_DATA_LO;
                    end else if (wait_cnt == WAIT_LAST) begin
                        state <= HS_IDLE;
                        tmo_q <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                HS_DATA_LO:  state <= HS_DATA_HI;
                HS_DATA_HI:  state <= HS_RET_TAR0;
                HS_RET_TAR0: state <= HS_RET_TAR1;
                HS_RET_TAR1: begin
                    state  <= HS_IDLE;
                    done_q <= 1'b1;
                end
                default: state <= HS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fwh_host_drive.sv
module fwh_host_drive
    import fwh_host_pkg::*;
(
    input  hstate_e              state,
    input  rd_req_t              req_q,
    input  logic [NIB_IDX_W-1:0] nib_idx,
    output bus_drv_t             drv
);

    always_comb begin
        drv.frame_n = 1'b1;
        drv.oe      = 1'b0;
        drv.dout    = CODE_ONES;
        unique case (state)
            HS_START: begin
                drv.frame_n = 1'b0;
                drv.oe      = 1'b1;
                drv.dout    = CODE_START;
            end
            HS_IDSEL: begin
                drv.oe   = 1'b1;
                drv.dout = req_q.id;
            end
            HS_ADDR: begin
                drv.oe   = 1'b1;
                drv.dout = addr_nibble(req_q.addr, nib_idx);
            end
            HS_SIZE: begin
                drv.oe   = 1'b1;
                drv.dout = CODE_SIZE1;
            end
            HS_TAR_DRIVE: begin
                drv.oe   = 1'b1;
                drv.dout = CODE_ONES;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/fwh_host_capture.sv
module fwh_host_capture
    import fwh_host_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  hstate_e           state,
    input  logic [NIB_W-1:0]  bus_din,
    output logic [BYTE_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (state == HS_DATA_LO) begin
            data_q[NIB_W-1:0] <= bus_din;
        end else if (state == HS_DATA_HI) begin
            data_q[BYTE_W-1:NIB_W] <= bus_din;
        end
    end

endmodule

// File: rtl/fwh_read_host.sv
module fwh_read_host
    import fwh_host_pkg::*;
#(
    parameter int SYNC_TIMEOUT = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [ID_W-1:0]     req_id,
    output logic                busy,
    output logic                done,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                sync_timeout,
    output logic                bus_frame_n,
    output logic [NIB_W-1:0]    bus_dout,
    output logic                bus_oe,
    input  logic [NIB_W-1:0]    bus_din
);

    hstate_e              state;
    rd_req_t              req_in;
    rd_req_t              req_q;
    logic [NIB_IDX_W-1:0] nib_idx;
    bus_drv_t             drv;

    assign req_in.addr = req_addr;
    assign req_in.id   = req_id;

    fwh_host_seq #(.SYNC_TIMEOUT(SYNC_TIMEOUT)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .bus_din   (bus_din),
        .state     (state),
        .req_q     (req_q),
        .nib_idx   (nib_idx),
        .done_q    (done),
        .tmo_q     (sync_timeout)
    );

    fwh_host_drive u_drive (
        .state   (state),
        .req_q   (req_q),
        .nib_idx (nib_idx),
        .drv     (drv)
    );

    fwh_host_capture u_cap (
        .clk     (clk),
        .rst     (rst),
        .state   (state),
        .bus_din (bus_din),
        .data_q  (rd_data)
    );

    assign busy        = (state != HS_IDLE);
    assign bus_frame_n = drv.frame_n;
    assign bus_oe      = drv.oe;
    assign bus_dout    = drv.dout;

endmodule

// File: rtl/fwh_read_host_chk.sv
module fwh_read_host_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       busy,
    input logic       done,
    input logic       sync_timeout,
    input logic       bus_frame_n,
    input logic [3:0] bus_dout,
    input logic       bus_oe
);

    // R2: the frame strobe only ever carries the start code
    p_frame_start_code_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_frame_n |-> (bus_oe && bus_dout == 4'b1101));

    // R2: the frame strobe lasts one clock
    p_frame_single_r2: assert property (@(posedge clk) disable iff (rst)
        !bus_frame_n |=> bus_frame_n);

    // R6: the bus is released only after an all-ones nibble
    p_release_after_ones_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_oe) |-> ($past(bus_dout) == 4'b1111));

    // R9: done is a one-clock pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: timeout is a one-clock pulse and never meets done
    p_tmo_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        sync_timeout |=> !sync_timeout);

    p_tmo_not_done_r10: assert property (@(posedge clk) disable iff (rst)
        !(sync_timeout && done));

    // R11: idle host never drives the bus
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bus_oe && bus_frame_n));

    // R11: an accepted request starts a frame next clock
    p_accept_frames_r11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> (busy && !bus_frame_n));

endmodule

bind fwh_read_host fwh_read_host_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .busy         (busy),
    .done         (done),
    .sync_timeout (sync_timeout),
    .bus_frame_n  (bus_frame_n),
    .bus_dout     (bus_dout),
    .bus_oe       (bus_oe)
);

// File: tb/tb_fwh_read_host.sv
`timescale 1ns/1ps
module tb_fwh_read_host;

    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [27:0] req_addr = '0;
    logic [3:0]  req_id = '0;
    logic        busy, done, sync_timeout, bus_frame_n, bus_oe;
    logic [7:0]  rd_data;
    logic [3:0]  bus_dout;
    logic [3:0]  bus_din = 4'hF;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fwh_read_host #(.SYNC_TIMEOUT(TMO)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_id(req_id), .busy(busy), .done(done), .rd_data(rd_data),
        .sync_timeout(sync_timeout), .bus_frame_n(bus_frame_n),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_nib(input logic [27:0] a, input int k);
        return a[27 - 4*k -: 4];
    endfunction

    function automatic logic [3:0] wait_code(input int r);
        logic [3:0] v;
        v = 4'(r);
        if (v == 4'h0) v = 4'hF;
        return v;
    endfunction

    // one full read; wt = number of non-ready sampling clocks before ready
    task automatic do_read(input logic [27:0] a, input logic [3:0] id,
                           input int wt, input logic [7:0] d, input bit junk);
        bit expect_tmo;
        expect_tmo = (wt >= TMO);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_id = id;
        @(negedge clk);
        if (junk) begin
            req_addr = ~a; req_id = ~id;
        end else begin
            req_valid = 1'b0;
        end
        chk("R2 frame low", {31'd0, bus_frame_n}, 32'd0);
        chk("R2 start code", {28'd0, bus_dout}, 32'hD);
        chk("R2 start oe", {31'd0, bus_oe}, 32'd1);
        chk("R11 busy", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R2 frame high", {31'd0, bus_frame_n}, 32'd1);
        chk("R3 id nibble", {28'd0, bus_dout}, {28'd0, id});
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            chk("R4 address nibble", {28'd0, bus_dout}, {28'd0, exp_nib(a, k)});
            chk("R4 oe", {31'd0, bus_oe}, 32'd1);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk("R5 size", {28'd0, bus_dout}, 32'd0);
        chk("R5 oe", {31'd0, bus_oe}, 32'd1);
        @(negedge clk);
        chk("R6 ones", {28'd0, bus_dout}, 32'hF);
        chk("R6 ones oe", {31'd0, bus_oe}, 32'd1);
        @(negedge clk);
        chk("R6 released", {31'd0, bus_oe}, 32'd0);
        if (expect_tmo) begin
            for (int w = 0; w < TMO; w++) begin
                @(negedge clk);
                bus_din = wait_code($urandom);
                if (bus_oe) chk("R6 undriven in wait", 32'd1, 32'd0);
            end
            @(negedge clk);
            bus_din = 4'hF;
            chk("R10 timeout flag", {31'd0, sync_timeout}, 32'd1);
            chk("R10 no done", {31'd0, done}, 32'd0);
            chk("R10 idle", {31'd0, busy}, 32'd0);
            chk("R10 bus quiet", {31'd0, bus_oe}, 32'd0);
            @(negedge clk);
            chk("R10 flag one clock", {31'd0, sync_timeout}, 32'd0);
        end else begin
            for (int w = 0; w <= wt; w++) begin
                @(negedge clk);
                bus_din = (w == wt) ? 4'h0 : wait_code($urandom);
                chk("R7 waiting busy", {31'd0, busy}, 32'd1);
            end
            @(negedge clk);
            bus_din = d[3:0];
            @(negedge clk);
            bus_din = d[7:4];
            @(negedge clk);
            bus_din = 4'hF;
            chk("R9 return turn 0 undriven", {31'd0, bus_oe}, 32'd0);
            chk("R9 no early done", {31'd0, done}, 32'd0);
            @(negedge clk);
            chk("R9 return turn 1 undriven", {31'd0, bus_oe}, 32'd0);
            chk("R11 busy till end", {31'd0, busy}, 32'd1);
            @(negedge clk);
            chk("R9 done", {31'd0, done}, 32'd1);
            chk("R8 byte order", {24'd0, rd_data}, {24'd0, d});
            chk("R9 busy low", {31'd0, busy}, 32'd0);
            chk("R10 no timeout on success", {31'd0, sync_timeout}, 32'd0);
            @(negedge clk);
            chk("R9 done one clock", {31'd0, done}, 32'd0);
            chk("R11 junk request ignored", {31'd0, bus_frame_n}, 32'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy", {31'd0, busy}, 32'd0);
        chk("R1 done", {31'd0, done}, 32'd0);
        chk("R1 timeout", {31'd0, sync_timeout}, 32'd0);
        chk("R1 oe", {31'd0, bus_oe}, 32'd0);
        chk("R1 frame", {31'd0, bus_frame_n}, 32'd1);

        // directed corners
        do_read(28'h1234567, 4'h3, 0, 8'h5A, 1'b0);
        do_read(28'hFFFFFFF, 4'hF, TMO - 1, 8'hC3, 1'b0);
        do_read(28'h0000000, 4'h0, TMO, 8'h00, 1'b0);
        do_read(28'hA5C3E10, 4'h9, 3, 8'h0F, 1'b1);
        do_read(28'h7654321, 4'h6, 1, 8'hF0, 1'b0);

        // random mix
        for (int n = 0; n < 40; n++) begin
            int wt;
            wt = ($urandom % 8 == 0) ? TMO + 2 : int'($urandom % TMO);
            do_read(28'($urandom), 4'($urandom), wt, 8'($urandom), 1'($urandom));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule